// File: doc/BRIEF.md
# Excluded-Tag Address Tagger

This unit returns a 64-bit address with a 4-bit logical tag written into bits [59:56]. The tag is chosen so that it is never a value the caller has excluded. Two 16-bit masks are merged into one exclusion set. The first is supplied with each request; a request without one drives zero. The second is a configured mask. In the merged set, bit i set forbids tag value i.

A mode input selects how the tag is picked:
- **Random mode:** the unit walks forward from a pseudo-random start value to the first permitted tag.
- **Seeded mode:** the unit starts from a persistent 4-bit seed, settles on the first permitted tag, then hops forward a pseudo-random number of permitted tags. The result is written back as the new seed.

An enable input forces the tag to zero. Requests use a valid strobe, and each result appears one clock later with its own valid strobe.

Top module: `tag_insert_unit`

## Requirements
- R1: After reset, `res_valid_o` is 0, the seed is 0, and the LFSR holds 16'hACE1.
- R2: The exclusion set is `sw_excl_i | cfg_excl_i`. While `tag_en_i` is 1 and the set is not all ones, the returned tag is never a value whose bit is set in it.
- R3: While `tag_en_i` is 0, the tag is 0 and the seed is unchanged, whatever the masks and mode.
- R4: In random mode (`rand_mode_i`=1) with all 16 exclusion bits set, the tag is 0.
- R5: In random mode, the tag is the first value at or after the LFSR's low nibble, counting upward modulo 16, whose exclusion bit is clear.
- R6: In seeded mode (`rand_mode_i`=0), take the first permitted value at or after the seed. Then advance to the next permitted value, strictly forward modulo 16, once for each count of the LFSR's low nibble. The value reached is the tag.
- R7: In seeded mode with all 16 exclusion bits set, the tag is 0 and the seed becomes 0.
- R8: The seed takes the returned tag only on a valid, enabled, seeded-mode request. Otherwise it holds.
- R9: `res_addr_o` equals the request's `addr_i`, except that bits [59:56] carry the tag. `res_tag_o` carries the same tag.
- R10: `res_valid_o` is high exactly one cycle after each cycle in which `req_valid_i` is high. The result fields belong to that request.
- R11: The LFSR is 16 bits wide. Each step shifts it left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It steps once per valid request in any mode and holds otherwise. Its value before the step supplies the nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| addr_i | input | 64 | Address operand |
| sw_excl_i | input | 16 | Per-request exclusion mask (0 when absent) |
| cfg_excl_i | input | 16 | Configured exclusion mask |
| rand_mode_i | input | 1 | 1 = random pick, 0 = seeded pick |
| tag_en_i | input | 1 | 0 forces a zero tag |
| res_valid_o | output | 1 | Result strobe |
| res_addr_o | output | 64 | Address with tag inserted |
| res_tag_o | output | 4 | Tag chosen |

## Verification
Every result, together with the seed and LFSR updates it causes, is due on the first rising edge after the request is presented. The result is then visible until the next edge. The driver applies each request on a falling edge and queues its expected result, computed from a model seed and a model LFSR. The monitor samples on the next falling edge, half a period after the result registers load, and pairs each valid result with the oldest queued item. Seed effects that cannot be seen directly are checked through the tag of a later seeded request.

// File: rtl/tagins_pkg.sv
package tagins_pkg;
  typedef enum logic {
    SEL_SEEDED = 1'b0,
    SEL_RANDOM = 1'b1
  } sel_mode_e;

  localparam int unsigned DEF_ADDR_W  = 64;
  localparam int unsigned DEF_TAG_W   = 4;
  localparam int unsigned DEF_TAG_LSB = 56;
  localparam int unsigned DEF_LFSR_W  = 16;
endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr #(
  parameter int unsigned            W    = 16,
  parameter logic [W-1:0]           INIT = 16'hACE1,
  parameter logic [W-1:0]           TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= INIT;
    else if (step_i) state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/tag_select.sv
module tag_select #(
  parameter int unsigned TAG_W = 4
) (
  input  logic [TAG_W-1:0]      start_i,
  input  logic [TAG_W-1:0]      hops_i,
  input  logic [(1<<TAG_W)-1:0] excl_i,
  output logic [TAG_W-1:0]      tag_o
);
  localparam int unsigned NTAGS = 1 << TAG_W;

  // first permitted value at or after s, wrapping
  function automatic logic [TAG_W-1:0] first_free(input logic [TAG_W-1:0] s,
                                                  input logic [NTAGS-1:0] m);
    logic [TAG_W-1:0] r;
    logic [TAG_W-1:0] c;
    logic             hit;
    r   = s;
    hit = 1'b0;
    for (int k = 0; k < NTAGS; k++) begin
      c = s + TAG_W'(k);
      if (!hit && !m[c]) begin
        r   = c;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [TAG_W-1:0] stage [NTAGS];
  logic             all_excl;

  assign all_excl = &excl_i;
  assign stage[0] = first_free(start_i, excl_i);

  for (genvar j = 0; j < NTAGS - 1; j++) begin : g_hop
    assign stage[j+1] = first_free(stage[j] + TAG_W'(1), excl_i);
  end

  assign tag_o = all_excl ? '0 : stage[hops_i];
endmodule

// File: rtl/tag_place.sv
module tag_place #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned TAG_LSB = 56
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    addr_o                    = addr_i;
    addr_o[TAG_LSB +: TAG_W]  = tag_i;
  end
endmodule

// File: rtl/tag_insert_unit.sv
module tag_insert_unit
  import tagins_pkg::*;
#(
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned TAG_W     = DEF_TAG_W,
  parameter int unsigned TAG_LSB   = DEF_TAG_LSB,
  parameter int unsigned LFSR_W    = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [(1<<TAG_W)-1:0]   sw_excl_i,
  input  logic [(1<<TAG_W)-1:0]   cfg_excl_i,
  input  logic                    rand_mode_i,
  input  logic                    tag_en_i,
  output logic                    res_valid_o,
  output logic [ADDR_W-1:0]       res_addr_o,
  output logic [TAG_W-1:0]        res_tag_o
);
  localparam int unsigned NTAGS = 1 << TAG_W;

  sel_mode_e         mode;
  logic [NTAGS-1:0]  excl;
  logic [LFSR_W-1:0] lfsr_state;
  logic [TAG_W-1:0]  nib;
  logic [TAG_W-1:0]  seed_q;
  logic [TAG_W-1:0]  start, hops, picked, tag_d;
  logic [ADDR_W-1:0] placed;
  logic              seed_we;

  logic              res_valid_q;
  logic [ADDR_W-1:0] res_addr_q;
  logic [TAG_W-1:0]  res_tag_q;

  assign mode = sel_mode_e'(rand_mode_i);
  assign excl = sw_excl_i | cfg_excl_i;
  assign nib  = lfsr_state[TAG_W-1:0];

  tag_lfsr #(
    .W    (LFSR_W),
    .INIT (LFSR_INIT),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (req_valid_i),
    .state_o (lfsr_state)
  );

  // random mode: walk from the nibble with no hops; seeded: walk from seed, hop by nibble
  always_comb begin
    if (mode == SEL_RANDOM) begin
      start = nib;
      hops  = '0;
    end else begin
      start = seed_q;
      hops  = nib;
    end
  end

  tag_select #(
    .TAG_W (TAG_W)
  ) u_select (
    .start_i (start),
    .hops_i  (hops),
    .excl_i  (excl),
    .tag_o   (picked)
  );

  assign tag_d   = tag_en_i ? picked : '0;
  assign seed_we = req_valid_i && tag_en_i && (mode == SEL_SEEDED);

  tag_place #(
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W),
    .TAG_LSB (TAG_LSB)
  ) u_place (
    .addr_i (addr_i),
    .tag_i  (tag_d),
    .addr_o (placed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seed_q <= '0;
    else if (seed_we) seed_q <= tag_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_addr_q  <= '0;
      res_tag_q   <= '0;
    end else begin
      res_valid_q <= req_valid_i;
      if (req_valid_i) begin
        res_addr_q <= placed;
        res_tag_q  <= tag_d;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_addr_o  = res_addr_q;
  assign res_tag_o   = res_tag_q;
endmodule

// File: rtl/tag_insert_unit_chk.sv
module tag_insert_unit_chk #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned TAG_LSB = 56,
  parameter int unsigned LFSR_W  = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [(1<<TAG_W)-1:0] sw_excl_i,
  input logic [(1<<TAG_W)-1:0] cfg_excl_i,
  input logic                  rand_mode_i,
  input logic                  tag_en_i,
  input logic                  res_valid_o,
  input logic [ADDR_W-1:0]     res_addr_o,
  input logic [TAG_W-1:0]      res_tag_o,
  input logic [TAG_W-1:0]      seed_q,
  input logic [LFSR_W-1:0]     lfsr_state
);
  localparam int unsigned NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] excl_seen_q;
  logic             chk_excl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      excl_seen_q <= '0;
      chk_excl_q  <= 1'b0;
    end else begin
      excl_seen_q <= sw_excl_i | cfg_excl_i;
      chk_excl_q  <= req_valid_i && tag_en_i && !(&(sw_excl_i | cfg_excl_i));
    end
  end

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  p_excluded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_excl_q |-> !excl_seen_q[res_tag_o]);
  p_disabled_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !tag_en_i) |=> (res_tag_o == '0));
  // R4 and R7: a full mask yields a zero tag in either mode
  p_all_excl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (&(sw_excl_i | cfg_excl_i))) |=> (res_tag_o == '0));
  p_tag_field_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_addr_o[TAG_LSB +: TAG_W] == res_tag_o));
  p_passthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ((res_addr_o ^ $past(addr_i)) & ~({{(ADDR_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB)) == '0);
  p_seed_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tag_en_i && !rand_mode_i) |=> (seed_q == res_tag_o));
  p_seed_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && tag_en_i && !rand_mode_i) |=> $stable(seed_q));
  p_lfsr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(lfsr_state));
  p_lfsr_live_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0);
endmodule

bind tag_insert_unit tag_insert_unit_chk #(
  .ADDR_W  (ADDR_W),
  .TAG_W   (TAG_W),
  .TAG_LSB (TAG_LSB),
  .LFSR_W  (LFSR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .addr_i      (addr_i),
  .sw_excl_i   (sw_excl_i),
  .cfg_excl_i  (cfg_excl_i),
  .rand_mode_i (rand_mode_i),
  .tag_en_i    (tag_en_i),
  .res_valid_o (res_valid_o),
  .res_addr_o  (res_addr_o),
  .res_tag_o   (res_tag_o),
  .seed_q      (seed_q),
  .lfsr_state  (lfsr_state)
);

// File: tb/tag_insert_unit_tb_top.sv
module tag_insert_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  typedef struct {
    logic [63:0] addr;
    logic [3:0]  tag;
    string       rq;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic [15:0] sw_excl_i = '0;
  logic [15:0] cfg_excl_i = '0;
  logic        rand_mode_i = 1'b0;
  logic        tag_en_i = 1'b0;
  logic        res_valid_o;
  logic [63:0] res_addr_o;
  logic [3:0]  res_tag_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t sb_q[$];

  // reference state, from R1 / R6 / R8 / R11
  logic [3:0]  m_seed = 4'h0;
  logic [15:0] m_lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tag_insert_unit dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .addr_i      (addr_i),
    .sw_excl_i   (sw_excl_i),
    .cfg_excl_i  (cfg_excl_i),
    .rand_mode_i (rand_mode_i),
    .tag_en_i    (tag_en_i),
    .res_valid_o (res_valid_o),
    .res_addr_o  (res_addr_o),
    .res_tag_o   (res_tag_o)
  );

  function automatic logic [3:0] nxt_ok(input logic [3:0] s, input logic [15:0] m);
    for (int k = 0; k < 16; k++) begin
      if (!m[4'(s + 4'(k))]) return 4'(s + 4'(k));
    end
    return 4'h0;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] a, input logic [15:0] sw, input logic [15:0] cfg,
                       input logic rnd, input logic en, input string rq);
    logic [15:0] m;
    logic [3:0]  nib, t;
    exp_t        e;
    @(negedge clk_i);
    req_valid_i = 1'b1; addr_i = a; sw_excl_i = sw; cfg_excl_i = cfg;
    rand_mode_i = rnd; tag_en_i = en;
    m   = sw | cfg;
    nib = m_lfsr[3:0];
    if (!en || (&m)) t = 4'h0;
    else if (rnd) t = nxt_ok(nib, m);
    else begin
      t = nxt_ok(m_seed, m);
      for (int h = 0; h < 16; h++) if (h < int'(nib)) t = nxt_ok(4'(t + 4'd1), m);
    end
    e.addr = {a[63:60], t, a[55:0]};
    e.tag  = t;
    e.rq   = rq;
    sb_q.push_back(e);
    if (en && !rnd) m_seed = t;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    addr_i = 64'hDEAD_BEEF_0BAD_F00D;
    sw_excl_i = 16'hFFFF;
    rand_mode_i = 1'b0;
    tag_en_i = 1'b1;
    if (n > 1) repeat (n - 1) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && res_valid_o) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10 actual=unexpected result expected=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.rq, "/R9 addr"}, res_addr_o, e.addr);
        chk({e.rq, " tag"}, {60'h0, res_tag_o}, {60'h0, e.tag});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 valid after reset", {63'h0, res_valid_o}, 64'h0);
    rst_ni = 1'b1;
    // R1: first seeded request walks from seed 0 with reset LFSR nibble
    drive(64'h0123_4567_89AB_CDEF, 16'h0000, 16'h0000, 1'b0, 1'b1, "R1 R6 seeded clear");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 16'h00F0, 16'h0003, 1'b0, 1'b1, "R6 R2 seeded masked");
    drive(64'h0000_0000_0000_0000, 16'h5555, 16'h0000, 1'b0, 1'b1, "R6 R8 seeded odd only");
    drive(64'hA5A5_A5A5_A5A5_A5A5, 16'h0000, 16'h7FFF, 1'b0, 1'b1, "R6 R2 one tag left");
    // R5 random mode; seed must hold (R8), seen on the next seeded request
    drive(64'h1000_0000_0000_0001, 16'h0F0F, 16'h0000, 1'b1, 1'b1, "R5 R2 random");
    drive(64'h2000_0000_0000_0002, 16'h0000, 16'hFFFE, 1'b1, 1'b1, "R5 random single");
    drive(64'h3000_0000_0000_0003, 16'h0000, 16'h0000, 1'b0, 1'b1, "R8 seed held by random");
    drive(64'h4000_0000_0000_0004, 16'hFF00, 16'h00FF, 1'b1, 1'b1, "R4 random all excluded");
    drive(64'h5000_0000_0000_0005, 16'hFFFF, 16'h0000, 1'b0, 1'b1, "R7 seeded all excluded");
    drive(64'h6000_0000_0000_0006, 16'h0000, 16'h0000, 1'b0, 1'b1, "R7 seed now zero");
    // R3 disabled, then seeded to show seed held
    drive(64'h7F00_0000_0000_0007, 16'h0000, 16'h0000, 1'b0, 1'b0, "R3 disabled seeded");
    drive(64'h8F00_0000_0000_0008, 16'h1234, 16'h0000, 1'b1, 1'b0, "R3 disabled random");
    drive(64'h9000_0000_0000_0009, 16'h0000, 16'h0000, 1'b0, 1'b1, "R3 R8 seed held by disable");
    // omitted operand: only configured mask
    drive(64'hB000_0000_0000_000B, 16'h0000, 16'hAAAA, 1'b1, 1'b1, "R2 cfg only");
    // R11: idle gap must not step the LFSR; R10 no result during idle
    idle(5);
    drive(64'hC000_0000_0000_000C, 16'h0000, 16'h0000, 1'b1, 1'b1, "R11 R10 after idle");
    idle(1);
    drive(64'hDEAD_0000_BEEF_000D, 16'h0000, 16'h0000, 1'b0, 1'b1, "R11 R6 after idle");
    // mixed sweep
    for (int i = 0; i < 200; i++) begin
      drive({4'(i), 4'(~i), 24'(i * 7919), 32'(i * 104729)},
            16'(i * 40503), 16'((i % 5 == 0) ? 16'hFFFF : 16'(i * 2654)),
            1'(i % 3 == 0), 1'(i % 7 != 0), "R2 R5 R6 R9 sweep");
      if (i % 11 == 0) idle(2);
    end
    idle(3);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 actual=%0d pending expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule